// File: doc/BRIEF.md
# Flash Embedded-Operation Status Generator

This block produces the status byte that a NOR flash device returns when the host reads it while an embedded operation is running. A separate command decoder supplies the current operation state, a timeout flag, bit 7 of the byte last written, and the sector that is suspended. The host issues reads as requests carrying a sector field. Each accepted read produces one response byte. Depending on the operation and the sector that is read, that byte is either a status word or the array data supplied on an input port. Two status bits alternate from one completed read to the next. Their state is held in internal flip-flops that advance only when a read is accepted, and both flip-flops clear whenever the operation state is idle.

Reads use a valid/ready handshake on both sides. A request is accepted on a clock edge where `rd_valid` and `rd_ready` are both high. The response is held in a one-entry register: `rsp_valid` rises in the cycle after acceptance. While `rsp_valid` is high and `rsp_ready` is low, `rsp_data` holds its value and `rd_ready` is low, so no new read is taken. A new request can be accepted in the same cycle that the pending response is consumed. The ready/busy output is a plain level that depends only on the operation state.

Top module: `flash_status_gen`

## Requirements
- R1: While `rst_n` is low and after it is released, `rsp_valid` is 0 and both alternating bits start at 0, so the first status word after reset has bit 6 = 0.
- R2: `op_state` codes are 0 idle, 1 program, 2 erase, 3 erase-suspended, 4 program-suspended, 5 buffer busy, 6 buffer aborted, 7 program inside erase-suspend. `ready_busy` is 1 for codes 0, 3 and 4, and 0 for all other codes.
- R3: For codes 1, 5 and 7, a read returns bit 7 = NOT `wr_msb`, and bit 6 = 0 then 1 on successive accepted reads. Bit 5 follows R5 and all other bits are 0.
- R4: For code 2, a read returns bit 7 = 0 and bit 3 = 1. Bits 6 and 2 each alternate on every accepted read. Bit 5 follows R5 and the other bits are 0.
- R5: In codes 1, 2, 5, 6 and 7, bit 5 of the status word equals `timeout`. In every other status word bit 5 is 0, and `timeout` has no effect in idle.
- R6: For code 6, the word is the same as for code 5 except that bit 1 = 1.
- R7: For code 3, a read whose `rd_sector` equals `susp_sector` returns bit 7 = 1 and bit 2 alternating. Bit 6 keeps its last value without advancing, and the other bits are 0.
- R8: In codes 0, 3 and 4, a read whose sector differs from `susp_sector` (and any read in code 0) returns `array_data`.
- R9: For code 4, a read of the suspended sector returns 8'hFF and advances neither alternating bit.
- R10: A read is taken only when `rd_valid` and `rd_ready` are both high. While a response is stalled, `rsp_data` is stable and `rd_ready` is 0, and the alternating bits do not advance.
- R11: A clock edge with `op_state` = 0 clears both alternating bits, so the next status word starts again with bits 6 and 2 at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_state | input | 3 | Current operation code (see R2) |
| timeout | input | 1 | Operation exceeded its time limit |
| wr_msb | input | 1 | Bit 7 of the byte being written |
| susp_sector | input | SEC_W | Sector that is suspended |
| array_data | input | 8 | Stored array byte for the addressed location |
| rd_valid | input | 1 | Read request valid |
| rd_ready | output | 1 | Read request can be accepted |
| rd_sector | input | SEC_W | Sector field of the read address |
| rsp_valid | output | 1 | Response byte valid |
| rsp_ready | input | 1 | Host takes the response |
| rsp_data | output | 8 | Status word or array data |
| ready_busy | output | 1 | 1 = ready, 0 = busy |

## Verification
The hardest case to reach is a stalled response: the alternating bits must not advance while `rd_valid` stays high and `rsp_ready` is low, and a new read must be accepted in the same cycle that the old response drains. The bench holds `rsp_ready` low across a repeated request, then releases it for one cycle with the request still present. It expects the next word to carry bit 6 advanced by exactly one step. The vector walk also places the suspended modes between busy modes. This shows that bit 6 holds through erase-suspend and program-suspend reads and then resumes from the held value.

// File: rtl/flash_status_pkg.sv
package flash_status_pkg;
  localparam int DW = 8;
  localparam int NTOG = 2;
  localparam int T6 = 0;
  localparam int T2 = 1;

  typedef enum logic [2:0] {
    OP_IDLE      = 3'd0,
    OP_PROG      = 3'd1,
    OP_ERASE     = 3'd2,
    OP_ESUSP     = 3'd3,
    OP_PSUSP     = 3'd4,
    OP_BUF_BUSY  = 3'd5,
    OP_BUF_ABORT = 3'd6,
    OP_ES_PROG   = 3'd7
  } op_e;

  function automatic logic op_is_busy(input op_e op);
    return !(op == OP_IDLE || op == OP_ESUSP || op == OP_PSUSP);
  endfunction
endpackage

// File: rtl/fsg_toggle_bank.sv
module fsg_toggle_bank #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic [N-1:0] adv,
  output logic [N-1:0] q
);
  for (genvar g = 0; g < N; g++) begin : g_tog
    always_ff @(posedge clk) begin
      if (!rst_n || clr) q[g] <= 1'b0;
      else if (adv[g])   q[g] <= ~q[g];
    end
  end
endmodule

// File: rtl/fsg_status_encode.sv
module fsg_status_encode
  import flash_status_pkg::*;
#(
  parameter int SEC_W = 4
) (
  input  op_e                op,
  input  logic               timeout,
  input  logic               wr_msb,
  input  logic [SEC_W-1:0]   susp_sector,
  input  logic [SEC_W-1:0]   rd_sector,
  input  logic [DW-1:0]      array_data,
  input  logic [NTOG-1:0]    tog,
  output logic [DW-1:0]      word,
  output logic [NTOG-1:0]    adv_req
);
  logic sec_hit;
  assign sec_hit = (rd_sector == susp_sector);

  always_comb begin
    word    = '0;
    adv_req = '0;
    unique case (op)
      OP_IDLE: word = array_data;
      OP_PROG, OP_ES_PROG, OP_BUF_BUSY, OP_BUF_ABORT: begin
        word[7]     = ~wr_msb;
        word[6]     = tog[T6];
        word[5]     = timeout;
        word[1]     = (op == OP_BUF_ABORT);
        adv_req[T6] = 1'b1;
      end
      OP_ERASE: begin
        word[6]     = tog[T6];
        word[5]     = timeout;
        word[3]     = 1'b1;
        word[2]     = tog[T2];
        adv_req[T6] = 1'b1;
        adv_req[T2] = 1'b1;
      end
      OP_ESUSP: begin
        if (sec_hit) begin
          word[7]     = 1'b1;
          word[6]     = tog[T6];
          word[2]     = tog[T2];
          adv_req[T2] = 1'b1;
        end else begin
          word = array_data;
        end
      end
      OP_PSUSP: word = sec_hit ? '1 : array_data;
      default: word = array_data;
    endcase
  end
endmodule

// File: rtl/fsg_rsp_reg.sv
module fsg_rsp_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] din,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] dout
);
  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      dout      <= '0;
    end else if (in_valid && in_ready) begin
      out_valid <= 1'b1;
      dout      <= din;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/flash_status_gen.sv
module flash_status_gen
  import flash_status_pkg::*;
#(
  parameter int SEC_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [2:0]       op_state,
  input  logic             timeout,
  input  logic             wr_msb,
  input  logic [SEC_W-1:0] susp_sector,
  input  logic [7:0]       array_data,
  input  logic             rd_valid,
  output logic             rd_ready,
  input  logic [SEC_W-1:0] rd_sector,
  output logic             rsp_valid,
  input  logic             rsp_ready,
  output logic [7:0]       rsp_data,
  output logic             ready_busy
);
  op_e             op;
  logic [NTOG-1:0] tog;
  logic [NTOG-1:0] adv_req;
  logic [DW-1:0]   word;
  logic            fire;

  assign op         = op_e'(op_state);
  assign fire       = rd_valid && rd_ready;
  assign ready_busy = !op_is_busy(op);

  fsg_status_encode #(.SEC_W(SEC_W)) u_enc (
    .op(op), .timeout(timeout), .wr_msb(wr_msb),
    .susp_sector(susp_sector), .rd_sector(rd_sector),
    .array_data(array_data), .tog(tog),
    .word(word), .adv_req(adv_req)
  );

  fsg_toggle_bank #(.N(NTOG)) u_tog (
    .clk(clk), .rst_n(rst_n), .clr(op == OP_IDLE),
    .adv(adv_req & {NTOG{fire}}), .q(tog)
  );

  fsg_rsp_reg #(.W(DW)) u_rsp (
    .clk(clk), .rst_n(rst_n),
    .in_valid(rd_valid), .in_ready(rd_ready), .din(word),
    .out_valid(rsp_valid), .out_ready(rsp_ready), .dout(rsp_data)
  );
endmodule

// File: rtl/flash_status_gen_chk.sv
module flash_status_gen_chk #(
  parameter int SEC_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic [2:0]       op_state,
  input logic             timeout,
  input logic             wr_msb,
  input logic             rd_valid,
  input logic             rd_ready,
  input logic             rsp_valid,
  input logic             rsp_ready,
  input logic [7:0]       rsp_data,
  input logic             ready_busy
);
  logic fire;
  assign fire = rd_valid && rd_ready;

  AST_RESET_EMPTY: assert property (@(posedge clk) !rst_n |=> !rsp_valid); // R1
  AST_BUSY_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    (op_state == 3'd1 || op_state == 3'd2) |-> !ready_busy); // R2
  AST_PROG_B7: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && op_state == 3'd1) |=> (rsp_data[7] == !$past(wr_msb))); // R3
  AST_ERASE_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && op_state == 3'd2) |=> (rsp_data[3] && !rsp_data[7])); // R4
  AST_TIMEOUT_B5: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && op_state == 3'd2 && timeout) |=> rsp_data[5]); // R5
  AST_ABORT_B1: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && op_state == 3'd6) |=> rsp_data[1]); // R6
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data))); // R10
  AST_STALL_NO_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |-> !rd_ready); // R10
endmodule

bind flash_status_gen flash_status_gen_chk #(.SEC_W(SEC_W)) u_chk (.*);

// File: tb/flash_status_gen_test.sv
module flash_status_gen_test;
  localparam int CLK_PERIOD = 10;
  localparam int SEC_W = 4;
  localparam int NV = 19;
  localparam int WATCHDOG = 5000;

  // {op, timeout, wr_msb, sector, array_data, expected, ready_busy}
  localparam logic [25:0] VEC [NV] = '{
    {3'd0, 1'b0, 1'b0, 4'h5, 8'h5A, 8'h5A, 1'b1}, // R8 idle array
    {3'd1, 1'b0, 1'b1, 4'h3, 8'h00, 8'h00, 1'b0}, // R3 first b6=0
    {3'd1, 1'b0, 1'b1, 4'h3, 8'h00, 8'h40, 1'b0}, // R3 b6=1
    {3'd1, 1'b1, 1'b0, 4'h3, 8'h00, 8'hA0, 1'b0}, // R5
    {3'd2, 1'b0, 1'b0, 4'h3, 8'h00, 8'h48, 1'b0}, // R4
    {3'd2, 1'b0, 1'b0, 4'h3, 8'h00, 8'h0C, 1'b0}, // R4
    {3'd3, 1'b0, 1'b0, 4'h3, 8'h00, 8'hC0, 1'b1}, // R7
    {3'd3, 1'b0, 1'b0, 4'h3, 8'h00, 8'hC4, 1'b1}, // R7
    {3'd3, 1'b0, 1'b0, 4'h5, 8'h33, 8'h33, 1'b1}, // R8
    {3'd7, 1'b0, 1'b1, 4'h3, 8'h00, 8'h40, 1'b0}, // R3
    {3'd5, 1'b0, 1'b0, 4'h3, 8'h00, 8'h80, 1'b0}, // R3
    {3'd6, 1'b0, 1'b0, 4'h3, 8'h00, 8'hC2, 1'b0}, // R6
    {3'd6, 1'b1, 1'b1, 4'h3, 8'h00, 8'h22, 1'b0}, // R6
    {3'd4, 1'b0, 1'b0, 4'h3, 8'h00, 8'hFF, 1'b1}, // R9
    {3'd4, 1'b0, 1'b0, 4'h5, 8'h96, 8'h96, 1'b1}, // R8
    {3'd2, 1'b1, 1'b0, 4'h3, 8'h00, 8'h68, 1'b0}, // R5 / R9 no advance
    {3'd0, 1'b1, 1'b0, 4'h3, 8'h11, 8'h11, 1'b1}, // R11 idle clears
    {3'd1, 1'b0, 1'b1, 4'h3, 8'h00, 8'h00, 1'b0}, // R11 restart
    {3'd3, 1'b1, 1'b0, 4'h3, 8'h00, 8'hC0, 1'b1}  // R5 ignored in suspend
  };
  localparam string TAG [NV] = '{"R8", "R3", "R3", "R5", "R4", "R4", "R7",
    "R7", "R8", "R3", "R3", "R6", "R6", "R9", "R8", "R5", "R11", "R11", "R5"};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0] op_state = 3'd0;
  logic timeout = 1'b0;
  logic wr_msb = 1'b0;
  logic [SEC_W-1:0] susp_sector = 4'h3;
  logic [7:0] array_data = 8'h00;
  logic rd_valid = 1'b0;
  logic rd_ready;
  logic [SEC_W-1:0] rd_sector = '0;
  logic rsp_valid;
  logic rsp_ready = 1'b1;
  logic [7:0] rsp_data;
  logic ready_busy;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_status_gen #(.SEC_W(SEC_W)) uut (.*);

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic read_once(input logic [2:0] op, input logic to, input logic msb,
                           input logic [SEC_W-1:0] sec, input logic [7:0] arr);
    @(negedge clk);
    op_state = op; timeout = to; wr_msb = msb; rd_sector = sec; array_data = arr;
    rd_valid = 1'b1;
    @(negedge clk);
    rd_valid = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1", "rsp_valid in reset", int'(rsp_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", "rsp_valid after reset", int'(rsp_valid), 0);
    check("R2", "ready_busy idle", int'(ready_busy), 1);

    for (int i = 0; i < NV; i++) begin
      logic [25:0] v;
      v = VEC[i];
      read_once(v[25:23], v[22], v[21], v[20:17], v[16:9]);
      check(TAG[i], $sformatf("vector %0d rsp_valid", i), int'(rsp_valid), 1);
      check(TAG[i], $sformatf("vector %0d rsp_data", i), int'(rsp_data), int'(v[8:1]));
      check("R2", $sformatf("vector %0d ready_busy", i), int'(ready_busy), int'(v[0]));
    end

    // R10: stall with back-pressure; toggles start cleared via idle
    read_once(3'd0, 1'b0, 1'b0, 4'h5, 8'h00);
    @(negedge clk);
    op_state = 3'd1; wr_msb = 1'b0; rd_sector = 4'h3; rsp_ready = 1'b0; rd_valid = 1'b1;
    @(negedge clk);
    check("R10", "first stalled word", int'(rsp_data), 8'h80);
    check("R10", "rd_ready low while stalled", int'(rd_ready), 0);
    @(negedge clk);
    check("R10", "word held", int'(rsp_data), 8'h80);
    check("R10", "rsp_valid held", int'(rsp_valid), 1);
    rsp_ready = 1'b1;
    @(negedge clk);
    rd_valid = 1'b0;
    check("R10", "next word advanced once", int'(rsp_data), 8'hC0);
    @(negedge clk);
    check("R10", "drained", int'(rsp_valid), 0);

    // R1: reset in the middle of a program operation
    read_once(3'd1, 1'b0, 1'b0, 4'h3, 8'h00);
    check("R1", "pre-reset word", int'(rsp_data), 8'h80);
    rst_n = 1'b0;
    @(negedge clk);
    check("R1", "rsp_valid cleared", int'(rsp_valid), 0);
    rst_n = 1'b1;
    read_once(3'd1, 1'b0, 1'b0, 4'h3, 8'h00);
    check("R1", "bit6 restarts at 0", int'(rsp_data), 8'h80);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int c = 0; c < WATCHDOG; c++) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule